// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Change Interrupt

This block is the pin-side half of a serial-bus GPIO expander. It holds one output latch per pin and has no direction register. A latch at 0 pulls its pin low. A latch at 1 leaves the pin held high only by a weak pull-up, so an outside driver can pull it low and the pin works as an input. Writing a 1 also turns on a short strong pull-up enable for that pin. The enable stays on until the bus interface reports the next falling SCL edge. Pad drive strengths are given only as enable outputs.

Pin levels pass through a two-flop synchronizer. A read strobe copies them into a read register. An interrupt FSM compares the synchronized levels with a reference byte that is taken at each port access. The FSM has two states. In QUIET the interrupt is released. In ALERT it is driven low, open-drain style.
- QUIET to ALERT ("detect"): the levels differ from the reference and no clear event is present.
- ALERT to QUIET ("acknowledge"): a clear event arrives. This happens at the acknowledge bit of an access addressed to this port, on the rising SCL edge for a read and on the falling SCL edge for a write. The reference is reloaded at the same moment.
- ALERT to QUIET ("restore"): the pins go back to the reference levels without any access.

The serial protocol engine sits outside this block. It supplies the byte strobes, the select and acknowledge qualifiers, and the SCL edge pulses.

Top module: `qbp_port`

## Requirements
- R1: After reset all latches are 1: pin_pull_low is 0x00, pin_strong_up is 0x00, int_n is 1 and int_oe is 0.
- R2: A one-cycle wr_stb loads wr_data into the latches. From the next cycle, pin_pull_low equals the inverse of the written byte.
- R3: A write sets pin_strong_up for exactly the bits written as 1 and clears it for bits written as 0. A scl_rise pulse leaves pin_strong_up unchanged. A scl_fall pulse with no write in the same cycle clears every bit from the next cycle. A write wins over a scl_fall in the same cycle.
- R4: A one-cycle rd_stb captures the synchronized pin levels into rd_data on the next cycle. rd_data keeps its value when there is no strobe. A pin whose latch is 0 reads back as 0.
- R5: When any synchronized pin level differs from the reference, for a rise or a fall, int_n goes to 0 and int_oe to 1 no more than 3 cycles after the pin changes.
- R6: With acc_sel=1, acc_ack=1 and acc_rd=1, a scl_rise pulse releases the interrupt on the next cycle and reloads the reference. A scl_fall pulse in the same state does not release it.
- R7: With acc_sel=1, acc_ack=1 and acc_rd=0, a scl_fall pulse releases the interrupt on the next cycle and reloads the reference. A scl_rise pulse in the same state does not release it.
- R8: If the pins return to the reference levels with no access, the interrupt is released.
- R9: Acknowledge edges while acc_sel=0 leave the interrupt and the reference unchanged.
- R10: A pin change that comes after a release is reported again on int_n.
- R11: int_oe is 1 exactly when int_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | Byte write strobe, one cycle |
| wr_data | input | 8 | Byte to load into the latches |
| rd_stb | input | 1 | Byte read strobe, one cycle |
| rd_data | output | 8 | Pin levels captured at the last read strobe |
| acc_sel | input | 1 | The current bus access is addressed to this port |
| acc_ack | input | 1 | The bus is in the acknowledge bit of a byte |
| acc_rd | input | 1 | The current access is a read (1) or a write (0) |
| scl_rise | input | 1 | One-cycle pulse on a rising SCL edge |
| scl_fall | input | 1 | One-cycle pulse on a falling SCL edge |
| pin_in | input | 8 | Pad input levels |
| pin_pull_low | output | 8 | Strong low drive enable per pin |
| pin_strong_up | output | 8 | Transient strong pull-up enable per pin |
| int_n | output | 1 | Interrupt level, active low |
| int_oe | output | 1 | Interrupt pad drive enable, open-drain model |

## Verification
The bench goes after the edge polarity of each clear. It sends the wrong SCL edge during a read acknowledge and during a write acknowledge. A design that swapped the polarities would release the interrupt early, and one that cleared on either edge would fail both checks. Acknowledge edges for another device are sent while a change is pending; a design that ignored the select would drop the interrupt. The strong pull-up is checked through a rising SCL edge, which must not end it, and then a falling one, which must. The bench also checks that a pin restored with no access releases the interrupt, and that a later change raises it again. A design that latched the interrupt would fail the first of these, and one that compared against a stale reference would fail the second.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
    typedef enum logic {
        IRQ_QUIET = 1'b0,
        IRQ_ALERT = 1'b1
    } irq_state_e;
endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '1;
                end else begin
                    if (g == 0) stage_q[g] <= d;
                    else        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qbp_latch.sv
module qbp_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             scl_fall,
    output logic [WIDTH-1:0] pull_low,
    output logic [WIDTH-1:0] strong_up
);
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] boost_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '1;
            boost_q <= '0;
        end else begin
            if (wr_stb) begin
                latch_q <= wr_data;
                boost_q <= wr_data;
            end else if (scl_fall) begin
                boost_q <= '0;
            end
        end
    end

    assign pull_low  = ~latch_q;
    assign strong_up = boost_q;
endmodule

// File: rtl/qbp_irq.sv
module qbp_irq
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_s,
    input  logic             clr,
    output logic             int_n,
    output logic             int_oe
);
    irq_state_e       state_q, state_d;
    logic [WIDTH-1:0] ref_q;
    logic             differ;

    assign differ = (pin_s != ref_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: if (!clr && differ)  state_d = IRQ_ALERT;
            IRQ_ALERT: if (clr || !differ)  state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
            ref_q   <= '1;
        end else begin
            state_q <= state_d;
            if (clr) ref_q <= pin_s;
        end
    end

    always_comb begin
        int_n  = (state_q != IRQ_ALERT);
        int_oe = (state_q == IRQ_ALERT);
    end
endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
    parameter int WIDTH     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_stb,
    output logic [WIDTH-1:0] rd_data,
    input  logic             acc_sel,
    input  logic             acc_ack,
    input  logic             acc_rd,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_pull_low,
    output logic [WIDTH-1:0] pin_strong_up,
    output logic             int_n,
    output logic             int_oe
);
    logic [WIDTH-1:0] pin_s;
    logic [WIDTH-1:0] rd_q;
    logic             clr;

    qbp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk), .rst_n (rst_n), .d (pin_in), .q (pin_s)
    );

    qbp_latch #(.WIDTH(WIDTH)) u_latch (
        .clk (clk), .rst_n (rst_n), .wr_stb (wr_stb), .wr_data (wr_data),
        .scl_fall (scl_fall), .pull_low (pin_pull_low), .strong_up (pin_strong_up)
    );

    // Read acks clear on the rising edge, write acks on the falling edge.
    assign clr = acc_sel && acc_ack &&
                 ((acc_rd && scl_rise) || (!acc_rd && scl_fall));

    qbp_irq #(.WIDTH(WIDTH)) u_irq (
        .clk (clk), .rst_n (rst_n), .pin_s (pin_s), .clr (clr),
        .int_n (int_n), .int_oe (int_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_q <= '1;
        else if (rd_stb) rd_q <= pin_s;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/qbp_checker.sv
module qbp_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stb,
    input logic [WIDTH-1:0] wr_data,
    input logic             rd_stb,
    input logic [WIDTH-1:0] rd_data,
    input logic             acc_sel,
    input logic             acc_ack,
    input logic             acc_rd,
    input logic             scl_rise,
    input logic             scl_fall,
    input logic [WIDTH-1:0] pin_pull_low,
    input logic [WIDTH-1:0] pin_strong_up,
    input logic             int_n,
    input logic             int_oe
);
    p_wr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (pin_pull_low == ~$past(wr_data)));

    p_boost_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && !wr_stb) |=> (pin_strong_up == '0));

    p_boost_only_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_strong_up & pin_pull_low) == '0));

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && acc_ack && acc_rd && scl_rise) |=> int_n);

    p_wr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel && acc_ack && !acc_rd && scl_fall) |=> int_n);

    p_open_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_oe != int_n));
endmodule

bind qbp_port qbp_checker #(.WIDTH(WIDTH)) u_chk (
    .clk (clk), .rst_n (rst_n), .wr_stb (wr_stb), .wr_data (wr_data),
    .rd_stb (rd_stb), .rd_data (rd_data), .acc_sel (acc_sel),
    .acc_ack (acc_ack), .acc_rd (acc_rd), .scl_rise (scl_rise),
    .scl_fall (scl_fall), .pin_pull_low (pin_pull_low),
    .pin_strong_up (pin_strong_up), .int_n (int_n), .int_oe (int_oe)
);

// File: tb/qbp_port_bench.sv
`timescale 1ns/1ps
module qbp_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       acc_sel = 1'b0, acc_ack = 1'b0, acc_rd = 1'b0;
    logic       scl_rise = 1'b0, scl_fall = 1'b0;
    logic [7:0] ext = 8'hFF;
    logic [7:0] pin_in;
    logic [7:0] pin_pull_low, pin_strong_up;
    logic       int_n, int_oe;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    // pad model: a latch at 0 forces the pin low
    assign pin_in = ext & ~pin_pull_low;

    qbp_port u_qbp_port (
        .clk (clk), .rst_n (rst_n), .wr_stb (wr_stb), .wr_data (wr_data),
        .rd_stb (rd_stb), .rd_data (rd_data), .acc_sel (acc_sel),
        .acc_ack (acc_ack), .acc_rd (acc_rd), .scl_rise (scl_rise),
        .scl_fall (scl_fall), .pin_in (pin_in), .pin_pull_low (pin_pull_low),
        .pin_strong_up (pin_strong_up), .int_n (int_n), .int_oe (int_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_irq(input string req, input logic exp_n);
        check(req, {7'd0, int_n}, {7'd0, exp_n});
        check({req, "/R11"}, {7'd0, int_oe}, {7'd0, ~exp_n});
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_stb = 1'b1; wr_data = v; tick(1); wr_stb = 1'b0;
    endtask

    task automatic edge_pulse(input logic sel, input logic rd, input logic rise);
        acc_sel = sel; acc_ack = 1'b1; acc_rd = rd;
        if (rise) scl_rise = 1'b1; else scl_fall = 1'b1;
        tick(1);
        scl_rise = 1'b0; scl_fall = 1'b0; acc_ack = 1'b0; acc_sel = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 pull_low", pin_pull_low, 8'h00);
        check("R1 strong_up", pin_strong_up, 8'h00);
        check_irq("R1 int", 1'b1);
    endtask

    task automatic t_write_and_wr_clear;
        do_write(8'hA5);
        check("R2 pull_low", pin_pull_low, 8'h5A);
        check("R3 strong set", pin_strong_up, 8'hA5);
        edge_pulse(1'b0, 1'b0, 1'b1);
        check("R3 kept over rise", pin_strong_up, 8'hA5);
        tick(3);
        check_irq("R5 falling pins", 1'b0);
        edge_pulse(1'b1, 1'b0, 1'b1);      // wrong edge for a write
        check_irq("R7 rise ignored", 1'b0);
        check("R3 strong before fall", pin_strong_up, 8'hA5);
        edge_pulse(1'b1, 1'b0, 1'b0);
        check_irq("R7 fall clears", 1'b1);
        check("R3 strong ended", pin_strong_up, 8'h00);
        tick(4);
        check_irq("R7 stays clear", 1'b1);
    endtask

    task automatic t_read_clear;
        do_write(8'hFF);
        tick(4);
        edge_pulse(1'b1, 1'b0, 1'b0);
        tick(1);
        check_irq("R7 reload", 1'b1);
        ext = 8'h3C;
        tick(3);
        check_irq("R5 change", 1'b0);
        rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
        check("R4 read", rd_data, 8'h3C);
        edge_pulse(1'b1, 1'b1, 1'b0);      // wrong edge for a read
        check_irq("R6 fall ignored", 1'b0);
        edge_pulse(1'b1, 1'b1, 1'b1);
        check_irq("R6 rise clears", 1'b1);
        ext = 8'hFF;
        tick(2);
        check("R4 hold", rd_data, 8'h3C);
        tick(2);
        edge_pulse(1'b1, 1'b1, 1'b1);
        tick(1);
    endtask

    task automatic t_other_device_and_restore;
        ext = 8'hFE;
        tick(4);
        check_irq("R5 bit0", 1'b0);
        edge_pulse(1'b0, 1'b1, 1'b1);
        edge_pulse(1'b0, 1'b0, 1'b0);
        tick(1);
        check_irq("R9 other device", 1'b0);
        ext = 8'hFF;
        tick(3);
        check_irq("R8 restore", 1'b1);
        ext = 8'h7F;
        tick(3);
        check_irq("R10 new change", 1'b0);
        ext = 8'hFF;
        tick(3);
        check_irq("R8 restore again", 1'b1);
    endtask

    task automatic t_latch_low_read;
        do_write(8'h0F);
        tick(3);
        rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
        check("R4 latch0 reads 0", rd_data, 8'h0F);
        wr_stb = 1'b1; wr_data = 8'hF0; scl_fall = 1'b1;
        tick(1);
        wr_stb = 1'b0; scl_fall = 1'b0;
        check("R3 write beats fall", pin_strong_up, 8'hF0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset;
        t_write_and_wr_clear;
        t_read_clear;
        t_other_device_and_restore;
        t_latch_low_read;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule